// File: doc/BRIEF.md
# Holdable Position Output Latch with Byte-Steered Tri-State Ports

This block sits between a free-running up/down position counter and a shared byte-wide data bus. It keeps a word-wide latch that follows the counter on every counter-update strobe. A host can freeze that latch with an active-low hold input while it reads the position. The counter itself is outside the block and keeps counting while the latch is frozen. When the hold is released, the block issues a one-cycle refresh strobe, and that strobe reloads the latch with the current counter value.

Two byte-wide ports present the latched word. The low port always carries the least significant byte. A byte-select input decides whether the high port carries the most significant byte or a copy of the least significant byte. Both ports have their own drive-enable outputs, which model tri-state behaviour for synthesis. An active-low output enable turns both drive-enables off and forces both data vectors to zero. A data-valid flag rises a configurable number of clock cycles after hold is asserted. This gives a refresh that is already in flight time to finish. The counter resolution is a parameter, and latch bits above that resolution always read zero.

Top module: `posn_hold_latch`

## Requirements
- R1: While `hold_n` is 0, the latched word does not change on any `cnt_upd` strobe or change of `cnt_val`, unless a refresh strobe is already in flight.
- R2: While `hold_n` is 1, a clock edge that samples `cnt_upd` = 1 loads `cnt_val` into the latch. The new value appears on the ports after that edge.
- R3: The first clock edge that samples `hold_n` = 1 after an edge that sampled it as 0 raises `refresh_req` for exactly one cycle. The next edge loads `cnt_val` into the latch.
- R4: When `oe_n` is 1, `hi_oe` and `lo_oe` are both 0 and `hi_d` and `lo_d` are both zero. When `oe_n` is 0, both drive-enables are 1.
- R5: When `oe_n` is 0, `lo_d` always equals bits [BYTE_W-1:0] of the latched word, whatever the value of `bsel`.
- R6: When `oe_n` is 0, `hi_d` equals bits [2*BYTE_W-1:BYTE_W] of the latched word if `bsel` is 1, and equals `lo_d` if `bsel` is 0.
- R7: Latched-word bits at index RES_BITS and above always read 0.
- R8: Changing `oe_n` or `bsel` never changes the latched word.
- R9: `data_valid` is 1 exactly when `hold_n` is 0 and at least SETTLE_CYC clock edges have sampled `hold_n` = 0 in a row. It drops as soon as `hold_n` returns to 1.
- R10: After reset the latched word is 0, and `refresh_req` and `data_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | RES_BITS | Current position counter value |
| cnt_upd | input | 1 | Counter-update strobe, one cycle per step |
| hold_n | input | 1 | Active-low latch hold |
| oe_n | input | 1 | Active-low output enable for both ports |
| bsel | input | 1 | High-port byte select (1 selects the high byte, 0 selects the low byte) |
| refresh_req | output | 1 | One-cycle refresh strobe issued on hold release |
| data_valid | output | 1 | Latched data has settled under hold |
| hi_d | output | BYTE_W | High-port data |
| hi_oe | output | 1 | High-port drive enable |
| lo_d | output | BYTE_W | Low-port data |
| lo_oe | output | 1 | Low-port drive enable |

## Verification
The bench builds the block with RES_BITS = 12, BYTE_W = 8 and SETTLE_CYC = 3. A 12-bit resolution leaves four unused bits in the high byte, which brings the zero-padding rule within reach. It is also small enough that every counter value can be loaded and read back through both byte-select settings. The short settle count lets the bench check the exact edge on which `data_valid` rises and the edge just before it. The bench also checks the edge-by-edge order of the release refresh and the reload.

// File: rtl/posn_hold_pkg.sv
package posn_hold_pkg;

   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } byte_pick_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/posn_hold_ctrl.sv
module posn_hold_ctrl #(
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n,
   output logic refresh_o,
   output logic valid_o
);
   import posn_hold_pkg::*;

   localparam int unsigned CNT_W = cnt_width(SETTLE_CYC);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

   logic             hold_prev_q;
   logic [CNT_W-1:0] settle_q;

   initial begin
      if (SETTLE_CYC < 1) $error("SETTLE_CYC must be at least 1");
   end

   // Release detector: a held edge followed by a free edge gives a single strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_prev_q <= 1'b1;
         refresh_o   <= 1'b0;
      end else begin
         hold_prev_q <= hold_n;
         refresh_o   <= hold_n & ~hold_prev_q;
      end
   end

   // Settle counter: saturates at the limit while hold is asserted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_q <= '0;
      end else if (hold_n) begin
         settle_q <= '0;
      end else if (settle_q != LIMIT) begin
         settle_q <= settle_q + 1'b1;
      end
   end

   assign valid_o = ~hold_n & (settle_q == LIMIT);

endmodule

// File: rtl/posn_word_latch.sv
module posn_word_latch #(
   parameter int unsigned RES_BITS = 16,
   parameter int unsigned WORD_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [RES_BITS-1:0] cnt_val,
   output logic [WORD_W-1:0]   word_q
);
   logic [WORD_W-1:0] padded;

   initial begin
      if (RES_BITS < 1 || RES_BITS > WORD_W)
         $error("RES_BITS must lie between 1 and WORD_W");
   end

   generate
      if (RES_BITS == WORD_W) begin : g_full
         assign padded = cnt_val;
      end else begin : g_pad
         assign padded = {{(WORD_W-RES_BITS){1'b0}}, cnt_val};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= padded;
   end

endmodule

// File: rtl/posn_byte_steer.sv
module posn_byte_steer #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] word,
   input  logic                oe_n,
   input  logic                bsel,
   output logic [BYTE_W-1:0]   hi_d,
   output logic                hi_oe,
   output logic [BYTE_W-1:0]   lo_d,
   output logic                lo_oe
);
   import posn_hold_pkg::*;

   logic [BYTE_W-1:0] low_b, high_b, hi_pick;
   byte_pick_e        pick;

   assign low_b  = word[BYTE_W-1:0];
   assign high_b = word[2*BYTE_W-1:BYTE_W];
   assign pick   = byte_pick_e'(bsel);

   always_comb begin
      unique case (pick)
         PICK_HIGH: hi_pick = high_b;
         default:   hi_pick = low_b;
      endcase
   end

   assign hi_oe = ~oe_n;
   assign lo_oe = ~oe_n;
   assign hi_d  = oe_n ? '0 : hi_pick;
   assign lo_d  = oe_n ? '0 : low_b;

endmodule

// File: rtl/posn_hold_latch.sv
module posn_hold_latch #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned RES_BITS   = 16,
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RES_BITS-1:0] cnt_val,
   input  logic                cnt_upd,
   input  logic                hold_n,
   input  logic                oe_n,
   input  logic                bsel,
   output logic                refresh_req,
   output logic                data_valid,
   output logic [BYTE_W-1:0]   hi_d,
   output logic                hi_oe,
   output logic [BYTE_W-1:0]   lo_d,
   output logic                lo_oe
);
   localparam int unsigned WORD_W = 2 * BYTE_W;

   logic              load;
   logic [WORD_W-1:0] latch_word;

   initial begin
      if (BYTE_W < 1) $error("BYTE_W must be at least 1");
   end

   posn_hold_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_n    (hold_n),
      .refresh_o (refresh_req),
      .valid_o   (data_valid)
   );

   assign load = (hold_n & cnt_upd) | refresh_req;

   posn_word_latch #(.RES_BITS(RES_BITS), .WORD_W(WORD_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .cnt_val (cnt_val),
      .word_q  (latch_word)
   );

   posn_byte_steer #(.BYTE_W(BYTE_W)) u_steer (
      .word  (latch_word),
      .oe_n  (oe_n),
      .bsel  (bsel),
      .hi_d  (hi_d),
      .hi_oe (hi_oe),
      .lo_d  (lo_d),
      .lo_oe (lo_oe)
   );

endmodule

// File: rtl/posn_hold_latch_chk.sv
module posn_hold_latch_chk #(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned RES_BITS = 16,
   parameter int unsigned WORD_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_n,
   input logic              oe_n,
   input logic              bsel,
   input logic              refresh_req,
   input logic              data_valid,
   input logic [BYTE_W-1:0] hi_d,
   input logic              hi_oe,
   input logic [BYTE_W-1:0] lo_d,
   input logic              lo_oe,
   input logic [WORD_W-1:0] latch_word
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_n && !refresh_req) |=> $stable(latch_word));

   // R3
   release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && hold_n && !$past(hold_n)) |=> refresh_req);

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |=> !refresh_req);

   // R4
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!hi_oe && !lo_oe && hi_d == '0 && lo_d == '0));

   // R5
   low_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (lo_d == latch_word[BYTE_W-1:0]));

   // R6
   high_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && bsel) |-> (hi_d == latch_word[WORD_W-1:BYTE_W]));

   // R6
   mirror_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && !bsel) |-> (hi_d == lo_d));

   // R9
   valid_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> !hold_n);

   generate
      if (RES_BITS < WORD_W) begin : g_pad_chk
         // R7
         pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n && bsel) |-> ({hi_d, lo_d} >> RES_BITS) == '0);
      end
   endgenerate

endmodule

bind posn_hold_latch posn_hold_latch_chk #(
   .BYTE_W(BYTE_W), .RES_BITS(RES_BITS), .WORD_W(WORD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hold_n      (hold_n),
   .oe_n        (oe_n),
   .bsel        (bsel),
   .refresh_req (refresh_req),
   .data_valid  (data_valid),
   .hi_d        (hi_d),
   .hi_oe       (hi_oe),
   .lo_d        (lo_d),
   .lo_oe       (lo_oe),
   .latch_word  (latch_word)
);

// File: tb/tb_posn_hold_latch.sv
`timescale 1ns/1ps
module tb_posn_hold_latch;
   localparam int BW  = 8;
   localparam int RES = 12;
   localparam int SET = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [RES-1:0] cnt_val = '0;
   logic           cnt_upd = 1'b0;
   logic           hold_n = 1'b1;
   logic           oe_n = 1'b1;
   logic           bsel = 1'b0;
   logic           refresh_req, data_valid, hi_oe, lo_oe;
   logic [BW-1:0]  hi_d, lo_d;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   posn_hold_latch #(.BYTE_W(BW), .RES_BITS(RES), .SETTLE_CYC(SET)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
      .hold_n(hold_n), .oe_n(oe_n), .bsel(bsel), .refresh_req(refresh_req),
      .data_valid(data_valid), .hi_d(hi_d), .hi_oe(hi_oe), .lo_d(lo_d), .lo_oe(lo_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Read the full word through the ports: high byte with bsel=1, then the mirror with bsel=0.
   task automatic read_word(input logic [15:0] exp, input string req);
      oe_n = 1'b0; bsel = 1'b1; #1;
      chk({hi_d, lo_d} == exp, req, {hi_d, lo_d}, exp);
      bsel = 1'b0; #1;
      chk(hi_d == exp[7:0] && lo_d == exp[7:0], req, {hi_d, lo_d}, {exp[7:0], exp[7:0]});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(refresh_req == 1'b0 && data_valid == 1'b0, "R10", {refresh_req, data_valid}, 0);
      read_word(16'h0000, "R10");
      rst_n = 1'b1;
      @(negedge clk);

      // R4 output disabled
      oe_n = 1'b1; #1;
      chk(!hi_oe && !lo_oe && hi_d == 0 && lo_d == 0, "R4", {hi_oe, lo_oe, hi_d, lo_d}, 0);
      oe_n = 1'b0; #1;
      chk(hi_oe && lo_oe, "R4", {hi_oe, lo_oe}, 2'b11);

      // R2 R5 R6 R7 exhaustive sweep over all counter values
      for (int v = 0; v < (1 << RES); v++) begin
         @(negedge clk);
         cnt_val = RES'(v); cnt_upd = 1'b1;
         @(negedge clk);
         cnt_upd = 1'b0;
         read_word(16'(v), "R2_R5_R6_R7");
      end

      // R8: oe_n and bsel toggling does not change the latch
      @(negedge clk);
      cnt_val = 12'hA5C; cnt_upd = 1'b1;
      @(negedge clk);
      cnt_upd = 1'b0; cnt_val = 12'h123;
      for (int k = 0; k < 4; k++) begin
         oe_n = k[0]; bsel = k[1];
         @(negedge clk);
      end
      read_word(16'h0A5C, "R8");

      // R1 and R9: hold asserted
      hold_n = 1'b0;
      for (int e = 1; e <= SET + 2; e++) begin
         if (e == 2) begin cnt_val = 12'h777; cnt_upd = 1'b1; end
         @(negedge clk);
         chk(data_valid == (e >= SET), "R9", data_valid, (e >= SET));
      end
      cnt_upd = 1'b0;
      read_word(16'h0A5C, "R1");

      // R3: release gives one refresh strobe, then a reload
      cnt_val = 12'h3E1;
      hold_n = 1'b1; #1;
      chk(data_valid == 1'b0, "R9", data_valid, 0);
      @(negedge clk);
      chk(refresh_req == 1'b1, "R3", refresh_req, 1);
      read_word(16'h0A5C, "R3");
      @(negedge clk);
      chk(refresh_req == 1'b0, "R3", refresh_req, 0);
      read_word(16'h03E1, "R3");

      // R1: strobe during hold with the latch visible throughout
      hold_n = 1'b0;
      held = 16'h03E1;
      for (int k = 0; k < 6; k++) begin
         cnt_val = RES'(k * 37 + 5); cnt_upd = 1'b1;
         @(negedge clk);
         read_word(held, "R1");
      end
      cnt_upd = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule